// File: doc/BRIEF.md
# Entropy Source Health Monitor

This block watches the serial bit stream of a single noise source and decides, bit by bit, whether the stream has degenerated. A bit is accepted on any clock where both the enable and the bit-valid strobe are high. Two independent run detectors look at the accepted bits.

- The first detector counts how long the current bit value has stayed unchanged.
- The second detector splits the stream into non-overlapping two-bit pairs. It counts how many times in a row the same alternating pair (01 or 10) has been seen.

If either count crosses its limit, the block reports a seed fault.

The fault is reported in two forms. A live status follows the stream: it goes high while a degenerate run is in progress and low as soon as the run is broken. A sticky flag is set when the live status goes high. It stays set until software writes a 0 to it, so a set sticky flag with a low live status means a fault happened and the stream has since recovered. The sticky flag, gated by an interrupt enable, drives a registered interrupt request. Dropping the enable clears all run tracking and the live status but keeps the sticky flag.

Top module: `entropy_health_mon`

## Requirements
- R1: The live error `live_err` goes high at the clock edge that accepts the 65th consecutive accepted bit of equal value, for either value. After 64 equal bits it is still low. A bit is accepted when `en` and `bit_valid` are both high.
- R2: An accepted bit that differs from the previous accepted bit restarts the constant run at 1. If the constant run was the only active fault, `live_err` falls at the edge that accepts the differing bit.
- R3: The constant-run count saturates and does not wrap. A run of 200 equal bits keeps `live_err` high from the 65th bit to the last.
- R4: Accepted bits form non-overlapping pairs starting with the first bit accepted after `en` rises. A pair is written first bit then second bit. `live_err` goes high at the edge that completes the 33rd consecutive identical pair when that pair is 01 or 10. It is still low after 32 such pairs and after the first bit of the 33rd.
- R5: A completed pair that is 00 or 11, or that differs from the previous pair, ends the pattern run. If no constant-run fault is present, `live_err` falls at the edge completing that pair.
- R6: `sticky_err` becomes 1 at the same clock edge at which `live_err` rises.
- R7: A write with `clr_wr`=1 and `clr_data`=0 clears `sticky_err` at the next edge, even while `live_err` stays high. A write with `clr_data`=1 has no effect. Without a clearing write, `sticky_err` stays set after `live_err` has fallen.
- R8: When `live_err` rises at the same edge as a clearing write, `sticky_err` ends up set.
- R9: `irq` is registered. At each edge it takes the new value of `sticky_err` AND the value of `irq_en` sampled at that edge.
- R10: While `en` is low, no bits are accepted and both run counts and `live_err` are zero at the next edge. `sticky_err` keeps its value. Runs restart from zero when `en` returns.
- R11: Synchronous active-high reset `rst` drives `live_err`, `sticky_err` and `irq` to 0.
- R12: Clocks with `bit_valid` low between accepted bits neither extend nor break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Monitor enable; low clears run tracking and live status |
| noise_bit | input | 1 | Sampled noise bit |
| bit_valid | input | 1 | Strobe marking `noise_bit` as a new sample |
| irq_en | input | 1 | Interrupt enable |
| clr_wr | input | 1 | Software write strobe to the sticky flag |
| clr_data | input | 1 | Value written; 0 clears the sticky flag |
| live_err | output | 1 | Live seed-fault status |
| sticky_err | output | 1 | Sticky seed-fault flag |
| irq | output | 1 | Interrupt request |

## Verification
The rise of the live error and a software clear of the sticky flag can land on the same clock edge. The bench provokes this by sending the 65th equal bit in the same cycle as a clearing write, and expects the sticky flag to remain set. A clearing write during a fault that persists is also exercised, where the clear must take effect because no new rise occurs. The interrupt enable changing while the sticky flag is already set is checked against the one-edge registered delay.

// File: rtl/ehm_pkg.sv
package ehm_pkg;

  typedef logic [1:0] pair_t;

  // A pair counts toward the pattern run only when its two bits differ.
  function automatic logic pair_is_alt(input pair_t p);
    return p[1] ^ p[0];
  endfunction

endpackage

// File: rtl/ehm_const_run.sv
module ehm_const_run #(
  parameter int RUN_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_i,
  input  logic valid_i,
  output logic hit_nxt
);

  localparam int CW = $clog2(RUN_LIMIT + 2);
  localparam logic [CW-1:0] SAT = CW'(RUN_LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_q;
  logic          have_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (valid_i) begin
      if (have_q && (bit_i == prev_q)) begin
        cnt_d = (cnt_q == SAT) ? SAT : cnt_q + CW'(1);
      end else begin
        cnt_d = CW'(1);
      end
    end
  end

  assign hit_nxt = (cnt_d > CW'(RUN_LIMIT));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (valid_i) begin
      cnt_q  <= cnt_d;
      prev_q <= bit_i;
      have_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ehm_pair_run.sv
module ehm_pair_run
  import ehm_pkg::*;
#(
  parameter int PAIR_LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_i,
  input  logic valid_i,
  output logic hit_nxt
);

  localparam int PW = $clog2(PAIR_LIMIT + 2);
  localparam logic [PW-1:0] SAT = PW'(PAIR_LIMIT + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          phase_q;
  logic          first_q;
  pair_t         last_q;
  logic          have_q;
  pair_t         cur_pair;
  logic          pair_done;

  assign cur_pair  = {first_q, bit_i};
  assign pair_done = en && valid_i && phase_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (pair_done) begin
      if (!pair_is_alt(cur_pair)) begin
        cnt_d = '0;
      end else if (have_q && (cur_pair == last_q)) begin
        cnt_d = (cnt_q == SAT) ? SAT : cnt_q + PW'(1);
      end else begin
        cnt_d = PW'(1);
      end
    end
  end

  assign hit_nxt = (cnt_d > PW'(PAIR_LIMIT));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      first_q <= 1'b0;
      last_q  <= '0;
      have_q  <= 1'b0;
    end else if (valid_i) begin
      if (!phase_q) begin
        first_q <= bit_i;
        phase_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_d;
        last_q  <= cur_pair;
        have_q  <= 1'b1;
        phase_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ehm_status.sv
module ehm_status (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hit_const,
  input  logic hit_pair,
  input  logic irq_en,
  input  logic clr_wr,
  input  logic clr_data,
  output logic live_err,
  output logic sticky_err,
  output logic irq
);

  logic live_d;
  logic rise;
  logic sw_clear;
  logic sticky_d;

  assign live_d   = en && (hit_const || hit_pair);
  assign rise     = live_d && !live_err;
  assign sw_clear = clr_wr && !clr_data;
  // A new fault wins over a clear arriving in the same cycle.
  assign sticky_d = rise || (sticky_err && !sw_clear);

  always_ff @(posedge clk) begin
    if (rst) begin
      live_err   <= 1'b0;
      sticky_err <= 1'b0;
      irq        <= 1'b0;
    end else begin
      live_err   <= live_d;
      sticky_err <= sticky_d;
      irq        <= sticky_d && irq_en;
    end
  end

endmodule

// File: rtl/entropy_health_mon.sv
module entropy_health_mon #(
  parameter int RUN_LIMIT  = 64,
  parameter int PAIR_LIMIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic noise_bit,
  input  logic bit_valid,
  input  logic irq_en,
  input  logic clr_wr,
  input  logic clr_data,
  output logic live_err,
  output logic sticky_err,
  output logic irq
);

  logic hit_const;
  logic hit_pair;

  ehm_const_run #(.RUN_LIMIT(RUN_LIMIT)) u_const (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .bit_i   (noise_bit),
    .valid_i (bit_valid),
    .hit_nxt (hit_const)
  );

  ehm_pair_run #(.PAIR_LIMIT(PAIR_LIMIT)) u_pair (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .bit_i   (noise_bit),
    .valid_i (bit_valid),
    .hit_nxt (hit_pair)
  );

  ehm_status u_status (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .hit_const  (hit_const),
    .hit_pair   (hit_pair),
    .irq_en     (irq_en),
    .clr_wr     (clr_wr),
    .clr_data   (clr_data),
    .live_err   (live_err),
    .sticky_err (sticky_err),
    .irq        (irq)
  );

endmodule

// File: rtl/ehm_checker.sv
module ehm_checker (
  input logic clk,
  input logic rst,
  input logic en,
  input logic clr_wr,
  input logic clr_data,
  input logic live_err,
  input logic sticky_err,
  input logic irq
);

  assert_sticky_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(live_err) |-> sticky_err);

  assert_irq_needs_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> sticky_err);

  assert_disable_clears_live_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !live_err);

  assert_sticky_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (sticky_err && !clr_wr) |=> sticky_err);

  assert_sticky_fall_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sticky_err) |-> $past(clr_wr && !clr_data));

endmodule

bind entropy_health_mon ehm_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .clr_wr     (clr_wr),
  .clr_data   (clr_data),
  .live_err   (live_err),
  .sticky_err (sticky_err),
  .irq        (irq)
);

// File: tb/entropy_health_mon_bench.sv
`timescale 1ns/1ps
module entropy_health_mon_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, noise_bit = 1'b0, bit_valid = 1'b0;
  logic irq_en = 1'b0, clr_wr = 1'b0, clr_data = 1'b0;
  logic live_err, sticky_err, irq;

  int tests = 0;
  int fails = 0;
  string cur_req = "R11";

  always #4 clk = ~clk;

  entropy_health_mon u_entropy_health_mon (
    .clk(clk), .rst(rst), .en(en), .noise_bit(noise_bit), .bit_valid(bit_valid),
    .irq_en(irq_en), .clr_wr(clr_wr), .clr_data(clr_data),
    .live_err(live_err), .sticky_err(sticky_err), .irq(irq)
  );

  // Behavioural reference model
  int m_run, m_pcnt, m_prev_pair, pv;
  bit m_have, m_prev, m_phase, m_first, m_live, m_sticky, m_irq, m_old;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_pcnt = 0; m_prev_pair = -1; m_have = 0; m_prev = 0;
      m_phase = 0; m_first = 0; m_live = 0; m_sticky = 0; m_irq = 0;
    end else begin
      m_old = m_live;
      if (!en) begin
        m_run = 0; m_have = 0; m_pcnt = 0; m_phase = 0; m_prev_pair = -1; m_live = 0;
      end else if (bit_valid) begin
        if (m_have && noise_bit == m_prev) m_run++; else m_run = 1;
        m_prev = noise_bit; m_have = 1;
        if (!m_phase) begin
          m_first = noise_bit; m_phase = 1;
        end else begin
          pv = int'(m_first) * 2 + int'(noise_bit);
          if (pv == 1 || pv == 2) m_pcnt = (pv == m_prev_pair) ? m_pcnt + 1 : 1;
          else m_pcnt = 0;
          m_prev_pair = pv; m_phase = 0;
        end
        m_live = (m_run > 64) || (m_pcnt > 32);
      end
      if (m_live && !m_old) m_sticky = 1;
      else if (clr_wr && !clr_data) m_sticky = 0;
      m_irq = m_sticky && irq_en;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if ({live_err, sticky_err, irq} !== {m_live, m_sticky, m_irq}) begin
        fails++;
        $display("FAIL %s model compare: actual=%b%b%b expected=%b%b%b", cur_req,
                 live_err, sticky_err, irq, m_live, m_sticky, m_irq);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic send(input bit b, input bit clr);
    @(negedge clk);
    noise_bit = b; bit_valid = 1'b1; clr_wr = clr; clr_data = 1'b0;
    @(negedge clk);
    bit_valid = 1'b0; clr_wr = 1'b0;
  endtask

  task automatic send_n(input bit b, input int n);
    for (int i = 0; i < n; i++) send(b, 1'b0);
  endtask

  task automatic sw_write(input bit d);
    @(negedge clk);
    clr_wr = 1'b1; clr_data = d;
    @(negedge clk);
    clr_wr = 1'b0; clr_data = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    check("R11", live_err, 1'b0, "live in reset");
    check("R11", sticky_err, 1'b0, "sticky in reset");
    check("R11", irq, 1'b0, "irq in reset");
    rst = 1'b0; en = 1'b1; irq_en = 1'b1;
    @(negedge clk);

    // Constant run of ones
    cur_req = "R1";
    send_n(1'b1, 64);
    check("R1", live_err, 1'b0, "after 64 ones");
    send(1'b1, 1'b0);
    check("R1", live_err, 1'b1, "after 65 ones");
    check("R6", sticky_err, 1'b1, "sticky with rise");
    check("R9", irq, 1'b1, "irq with sticky");
    cur_req = "R3";
    for (int i = 0; i < 135; i++) begin
      send(1'b1, 1'b0);
      @(negedge clk);   // extra idle gap, R12
      if (live_err !== 1'b1) check("R3", live_err, 1'b1, "saturated run");
    end
    check("R12", live_err, 1'b1, "gaps keep run");
    cur_req = "R2";
    send(1'b0, 1'b0);
    check("R2", live_err, 1'b0, "break by differing bit");
    check("R7", sticky_err, 1'b1, "sticky after recovery");
    cur_req = "R7";
    sw_write(1'b1);
    check("R7", sticky_err, 1'b1, "write 1 ignored");
    sw_write(1'b0);
    check("R7", sticky_err, 1'b0, "write 0 clears");
    check("R9", irq, 1'b0, "irq follows clear");

    // Constant run of zeros, interrupt masked
    cur_req = "R9";
    restart();
    irq_en = 1'b0;
    send_n(1'b0, 65);
    check("R1", live_err, 1'b1, "after 65 zeros");
    check("R9", irq, 1'b0, "irq masked");
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    check("R9", irq, 1'b1, "irq after enable");
    cur_req = "R7";
    sw_write(1'b0);
    check("R7", sticky_err, 1'b0, "clear during persisting fault");
    check("R7", live_err, 1'b1, "live persists");
    send(1'b1, 1'b0);
    check("R2", live_err, 1'b0, "zeros broken");

    // Disable resets runs
    cur_req = "R10";
    restart();
    send_n(1'b1, 64);
    restart();
    send_n(1'b1, 10);
    check("R10", live_err, 1'b0, "run restarted after disable");
    @(negedge clk); en = 1'b0;
    send_n(1'b1, 70);
    check("R10", live_err, 1'b0, "bits ignored while disabled");
    @(negedge clk); en = 1'b1;

    // Pair pattern 01
    cur_req = "R4";
    restart();
    for (int i = 0; i < 32; i++) begin send(1'b0, 1'b0); send(1'b1, 1'b0); end
    check("R4", live_err, 1'b0, "after 32 pairs");
    send(1'b0, 1'b0);
    check("R4", live_err, 1'b0, "mid 33rd pair");
    send(1'b1, 1'b0);
    check("R4", live_err, 1'b1, "after 33 pairs 01");
    check("R6", sticky_err, 1'b1, "sticky on pair fault");
    cur_req = "R5";
    send(1'b1, 1'b0);
    check("R5", live_err, 1'b1, "first bit of differing pair");
    send(1'b0, 1'b0);
    check("R5", live_err, 1'b0, "pair 10 after 01 breaks");

    // Pair pattern 10 broken by 11
    cur_req = "R5";
    restart();
    for (int i = 0; i < 33; i++) begin send(1'b1, 1'b0); send(1'b0, 1'b0); end
    check("R4", live_err, 1'b1, "after 33 pairs 10");
    send(1'b1, 1'b0); send(1'b1, 1'b0);
    check("R5", live_err, 1'b0, "pair 11 breaks");

    // Collision of rise and clear
    cur_req = "R8";
    restart();
    sw_write(1'b0);
    check("R7", sticky_err, 1'b0, "cleared before collision");
    send_n(1'b1, 64);
    send(1'b1, 1'b1);
    check("R8", live_err, 1'b1, "rise in collision");
    check("R8", sticky_err, 1'b1, "set wins over clear");
    cur_req = "R10";
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R10", live_err, 1'b0, "disable drops live");
    check("R10", sticky_err, 1'b1, "disable keeps sticky");
    en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule